// File: doc/BRIEF.md
# Credit-Based Transmit Shaper

This block paces one transmit queue by keeping a signed credit balance and allowing a new frame to start only when that balance is zero or higher. Software converts the desired bandwidth into four unsigned per-queue settings:

- The idle slope is the requested rate × 1024 × a speed factor ÷ a speed divisor. The factor is 4 at 100M, 8 at 1G and 2.5G, and 32 at 5G and 10G.
- The send slope is worked out the same way from the size of the negative send rate.
- The upper and lower credit bounds are the requested credit values × 8192.

Because all four settings arrive already scaled, the block only adds and subtracts integers.

The credit changes once per slot tick. It grows while a frame waits and the queue is not sending. It shrinks while the queue is sending. When nothing is pending it settles back toward zero. Shaping is switched on per queue. Queue 0 is never shaped, so the instance for that queue keeps its enable tied low. With shaping off, the queue is always eligible. Choosing between queues and moving frame data are handled by other blocks.

Top module: `cbs_shaper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it drops, `credit` is 0 and `tx_eligible` is 1.
- R2: On a tick with shaping on, `frame_pending` high and `tx_active` low, credit grows by `idle_slope` and is capped at `hi_credit`.
- R3: On a tick with shaping on and `tx_active` high, credit drops by `send_slope` and never goes below minus `lo_credit`.
- R4: On a tick with shaping on, both `frame_pending` and `tx_active` low, and credit above 0, credit becomes exactly 0.
- R5: On a tick with shaping on, both `frame_pending` and `tx_active` low, and credit at or below 0, credit grows by `idle_slope` and never goes above 0.
- R6: In a cycle with shaping on and `tick` low, credit keeps its value.
- R7: With shaping on, `tx_eligible` is 1 exactly when the `credit` value shown in the same cycle is 0 or more.
- R8: In the cycle after `shape_en` is low, `credit` is 0 and `tx_eligible` is 1, whatever `tick`, `frame_pending` and `tx_active` are.
- R9: When `tx_active` and `frame_pending` are both high on a tick, the send update of R3 applies and the idle slope is not added.
- R10: `credit` and `tx_eligible` are registered and change together, one clock after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Slot tick; credit may change only in a cycle where this is high |
| shape_en | input | 1 | Turns shaping on for this queue |
| frame_pending | input | 1 | A frame is waiting in the queue |
| tx_active | input | 1 | The queue is sending a frame |
| idle_slope | input | W | Amount credit grows per tick |
| send_slope | input | W | Amount credit drops per tick while sending |
| hi_credit | input | W | Upper credit bound |
| lo_credit | input | W | Size of the lower (negative) credit bound |
| tx_eligible | output | 1 | The queue may start a frame |
| credit | output | W+2 | Current credit, two's complement |

## Verification
Two things can happen in the same tick: the queue is sending while another frame is already pending, and the credit reaches one of its bounds. The random phase of the sweep drives `tx_active` and `frame_pending` together on many ticks, with slopes both larger and smaller than the bounds. Each of those cycles is judged against an arithmetic model in which sending wins and the result is clamped at minus `lo_credit`. Separate checks cover `shape_en` going low on a tick, where clearing must win over any slope update.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,
    ACT_CLEAR   = 3'd1,
    ACT_GAIN    = 3'd2,
    ACT_SPEND   = 3'd3,
    ACT_RECOVER = 3'd4
  } cbs_act_e;
endpackage

// File: rtl/cbs_act_dec.sv
module cbs_act_dec (
  input  logic               shape_en,
  input  logic               tick,
  input  logic               frame_pending,
  input  logic               tx_active,
  input  logic               credit_pos,
  output cbs_pkg::cbs_act_e  act
);
  import cbs_pkg::*;

  // Priority: disable > no tick > sending > waiting > settle toward zero
  always_comb begin
    if (!shape_en)          act = ACT_CLEAR;
    else if (!tick)         act = ACT_HOLD;
    else if (tx_active)     act = ACT_SPEND;
    else if (frame_pending) act = ACT_GAIN;
    else if (credit_pos)    act = ACT_CLEAR;
    else                    act = ACT_RECOVER;
  end
endmodule

// File: rtl/cbs_credit_calc.sv
module cbs_credit_calc #(
  parameter int W = 32
) (
  input  cbs_pkg::cbs_act_e    act,
  input  logic signed [W+1:0]  cur,
  input  logic [W-1:0]         idle_slope,
  input  logic [W-1:0]         send_slope,
  input  logic [W-1:0]         hi_credit,
  input  logic [W-1:0]         lo_credit,
  output logic signed [W+1:0]  nxt
);
  import cbs_pkg::*;
  localparam int AW = W + 2;

  logic signed [AW-1:0] idle_x, send_x, hi_x, lo_neg;
  logic signed [AW-1:0] sum, diff, gain_v, spend_v, recov_v;

  assign idle_x = $signed({2'b00, idle_slope});
  assign send_x = $signed({2'b00, send_slope});
  assign hi_x   = $signed({2'b00, hi_credit});
  assign lo_neg = -$signed({2'b00, lo_credit});

  // The two spare bits keep cur + idle and cur - send from wrapping
  assign sum  = cur + idle_x;
  assign diff = cur - send_x;

  assign gain_v  = (sum > hi_x)   ? hi_x   : sum;
  assign spend_v = (diff < lo_neg) ? lo_neg : diff;
  assign recov_v = (sum > 0)      ? '0     : sum;

  always_comb begin
    unique case (act)
      ACT_CLEAR:   nxt = '0;
      ACT_GAIN:    nxt = gain_v;
      ACT_SPEND:   nxt = spend_v;
      ACT_RECOVER: nxt = recov_v;
      default:     nxt = cur;
    endcase
  end
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                shape_en,
  input  logic                frame_pending,
  input  logic                tx_active,
  input  logic [W-1:0]        idle_slope,
  input  logic [W-1:0]        send_slope,
  input  logic [W-1:0]        hi_credit,
  input  logic [W-1:0]        lo_credit,
  output logic                tx_eligible,
  output logic signed [W+1:0] credit
);
  localparam int AW = W + 2;

  cbs_pkg::cbs_act_e    act;
  logic signed [AW-1:0] credit_nxt;
  logic                 credit_pos;

  assign credit_pos = (credit > 0);

  cbs_act_dec u_dec (
    .shape_en      (shape_en),
    .tick          (tick),
    .frame_pending (frame_pending),
    .tx_active     (tx_active),
    .credit_pos    (credit_pos),
    .act           (act)
  );

  cbs_credit_calc #(.W(W)) u_calc (
    .act        (act),
    .cur        (credit),
    .idle_slope (idle_slope),
    .send_slope (send_slope),
    .hi_credit  (hi_credit),
    .lo_credit  (lo_credit),
    .nxt        (credit_nxt)
  );

  // Eligibility is taken from the next credit so both outputs move together
  always_ff @(posedge clk) begin
    if (rst) begin
      credit      <= '0;
      tx_eligible <= 1'b1;
    end else begin
      credit      <= credit_nxt;
      tx_eligible <= !shape_en || !credit_nxt[AW-1];
    end
  end

  assert_cap_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (shape_en && tick && frame_pending && !tx_active)
      |=> (credit <= $signed({2'b00, $past(hi_credit)})));

  assert_floor_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (shape_en && tick && tx_active)
      |=> (credit >= -$signed({2'b00, $past(lo_credit)})));

  assert_settle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (shape_en && tick && !frame_pending && !tx_active && credit > 0)
      |=> (credit == 0));

  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (shape_en && !tick) |=> (credit == $past(credit)));

  assert_disabled_open_R8: assert property (@(posedge clk) disable iff (rst)
    !shape_en |=> (tx_eligible && credit == 0));
endmodule

// File: tb/cbs_shaper_bench.sv
module cbs_shaper_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, shape_en = 1'b0, frame_pending = 1'b0, tx_active = 1'b0;
  logic [W-1:0] idle_slope = '0, send_slope = '0, hi_credit = '0, lo_credit = '0;
  logic tx_eligible;
  logic signed [W+1:0] credit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint model_c = 0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  cbs_shaper #(.W(W)) u_cbs_shaper (
    .clk(clk), .rst(rst), .tick(tick), .shape_en(shape_en),
    .frame_pending(frame_pending), .tx_active(tx_active),
    .idle_slope(idle_slope), .send_slope(send_slope),
    .hi_credit(hi_credit), .lo_credit(lo_credit),
    .tx_eligible(tx_eligible), .credit(credit)
  );

  task automatic check(input string tag, input longint exp_c, input bit exp_e);
    longint act_c;
    act_c = longint'(credit);
    n_chk++;
    if (act_c != exp_c) begin
      n_fail++;
      $display("FAIL %s credit actual=%0d expected=%0d", tag, act_c, exp_c);
    end
    n_chk++;
    if (tx_eligible !== exp_e) begin
      n_fail++;
      $display("FAIL R7/%s eligible actual=%0b expected=%0b", tag, tx_eligible, exp_e);
    end
  endtask

  // Called at a negedge: drives one cycle, updates the model, checks at the next negedge (R10)
  task automatic step(input bit t, input bit en, input bit p, input bit s);
    string tag;
    tick = t; shape_en = en; frame_pending = p; tx_active = s;
    if (!en) begin
      model_c = 0; tag = "R8";
    end else if (!t) begin
      tag = "R6";
    end else if (s) begin
      model_c = model_c - longint'(send_slope);
      if (model_c < -longint'(lo_credit)) model_c = -longint'(lo_credit);
      tag = p ? "R9" : "R3";
    end else if (p) begin
      model_c = model_c + longint'(idle_slope);
      if (model_c > longint'(hi_credit)) model_c = longint'(hi_credit);
      tag = "R2";
    end else if (model_c > 0) begin
      model_c = 0; tag = "R4";
    end else begin
      model_c = model_c + longint'(idle_slope);
      if (model_c > 0) model_c = 0;
      tag = "R5";
    end
    @(negedge clk);
    check(tag, model_c, !en || model_c >= 0);
  endtask

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int idl[5] = '{1, 3, 7, 20, 255};
    int snd[4] = '{2, 5, 60, 255};
    int hil[3] = '{10, 100, 255};
    int lol[3] = '{0, 9, 200};
    repeat (3) @(negedge clk);
    check("R1", 0, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 0, 1'b1);
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 4; b++)
        for (int h = 0; h < 3; h++)
          for (int l = 0; l < 3; l++) begin
            idle_slope = W'(idl[a]); send_slope = W'(snd[b]);
            hi_credit = W'(hil[h]); lo_credit = W'(lol[l]);
            step(1'b1, 1'b0, 1'b0, 1'b0);               // R8 start from cleared credit
            for (int k = 0; k < 12; k++) step(1'b1, 1'b1, 1'b1, 1'b0);  // R2 climb to cap
            step(1'b0, 1'b1, 1'b1, 1'b1);               // R6 no tick
            for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'b0, 1'b1);  // R3 drain to floor
            for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b1, 1'b1);   // R9 both high
            for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 1'b0, 1'b0);   // R5 recovery
            for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 1'b1, 1'b0);
            step(1'b1, 1'b1, 1'b0, 1'b0);               // R4 positive credit settles
            for (int k = 0; k < 24; k++) begin
              lf = lfsr(lf);
              step(lf[0] | lf[1], lf[5:2] != 4'd0, lf[6], lf[7] & lf[8]);
            end
          end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule